// File: doc/BRIEF.md
# Debounced Input Conditioner with Edge Strobes

This block accepts one noisy asynchronous pin, such as a push button or a toggle switch, and turns it into clean signals in the system clock domain. The pin first passes through a short chain of flip-flops that resynchronises it. A stability counter then watches the resynchronised value. Only when that value has differed from the current clean level for a set number of consecutive cycles does the clean level take it.

The debounce counter and the edge logic form a single unit. Each time the clean level changes, the same clock edge also raises a one-cycle strobe: one strobe for a change from 0 to 1 and another for a change from 1 to 0. Logic downstream can therefore act on the strobe and the level together, without adding a cycle of its own. With a 50 MHz clock and a hold count of 10, any glitch shorter than 200 ns is rejected.

Top module: `input_conditioner`

## Requirements
- R1: After a synchronous reset, `clean_level`, `rise_pulse` and `fall_pulse` are all 0.
- R2: A change on `noisy_in` that persists appears on `clean_level` at the (SYNC_STAGES + WAIT_CYCLES)-th rising clock edge, counting the first edge that samples the new pin value as edge 1. With the defaults this is edge 12. `clean_level` keeps its old value at every earlier edge.
- R3: A pulse on `noisy_in` held for WAIT_CYCLES-1 cycles or fewer, in either direction, leaves `clean_level`, `rise_pulse` and `fall_pulse` unchanged.
- R4: A pulse on `noisy_in` held for exactly WAIT_CYCLES cycles is long enough to change `clean_level`.
- R5: `rise_pulse` is 1 for exactly one cycle, the same cycle in which `clean_level` goes from 0 to 1, and is 0 at every other time.
- R6: `fall_pulse` is 1 for exactly one cycle, the same cycle in which `clean_level` goes from 1 to 0, and is 0 at every other time.
- R7: A burst of toggles, each shorter than WAIT_CYCLES, followed by a settled value gives exactly one `clean_level` transition and exactly one strobe.
- R8: The stability count restarts from zero whenever the synchronised input equals `clean_level`. After such an interruption, a full new run of WAIT_CYCLES is needed, and the count never exceeds WAIT_CYCLES-1.
- R9: `rise_pulse` and `fall_pulse` are never 1 in the same cycle.
- R10: A reset asserted while `clean_level` is 1 clears the level, both strobes and the synchroniser at the next clock edge. After reset is released with the pin held high, the full latency of R2 applies again.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| noisy_in | input | 1 | Raw asynchronous pin |
| clean_level | output | 1 | Debounced level |
| rise_pulse | output | 1 | One-cycle strobe on a 0-to-1 change of the level |
| fall_pulse | output | 1 | One-cycle strobe on a 1-to-0 change of the level |

## Verification
Several properties hold on every cycle and are checked continuously:
- the stability count stays bounded;
- the level never flips unless the synchronised input disagreed with it in the previous cycle;
- each strobe lasts one cycle and coincides with a level change of its own direction;
- the two strobes never overlap;
- reset clears the outputs.

Some behaviour can only be shown by the bench's scenarios:
- the exact edge on which the level changes;
- the boundary between a rejected glitch of WAIT_CYCLES-1 cycles and an accepted pulse of WAIT_CYCLES cycles;
- the restart of the count after a one-cycle interruption;
- the clearing of the synchroniser by reset.

// File: rtl/incond_pkg.sv
package incond_pkg;

  // Width of a counter that must hold the values 0 .. hold-1.
  function automatic int count_bits(input int hold);
    return (hold <= 2) ? 1 : $clog2(hold);
  endfunction

  // Rising edges from the first edge that samples a pin change to the
  // edge that updates the clean level.
  function automatic int settle_latency(input int stages, input int hold);
    return stages + hold;
  endfunction

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_UP   = 2'd1,
    EDGE_DOWN = 2'd2
  } edge_kind_e;

endpackage

// File: rtl/incond_sync.sv
module incond_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[gi] <= 1'b0;
        else     chain_q[gi] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[gi] <= 1'b0;
        else     chain_q[gi] <= chain_q[gi-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/incond_debounce.sv
module incond_debounce
  import incond_pkg::*;
#(
  parameter int HOLD_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  output logic level,
  output logic rise,
  output logic fall
);

  localparam int CW = count_bits(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          level_q;
  logic          rise_q;
  logic          fall_q;

  // Internal events, named for the assertions below.
  logic       mismatch;
  logic       run_done;
  edge_kind_e next_edge;

  assign mismatch = (sample != level_q);
  assign run_done = mismatch && (run_cnt == LAST);

  always_comb begin
    next_edge = EDGE_NONE;
    if (run_done) next_edge = sample ? EDGE_UP : EDGE_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      if (!mismatch || run_done) run_cnt <= '0;
      else                       run_cnt <= run_cnt + CW'(1);
      if (run_done) level_q <= sample;
      rise_q <= (next_edge == EDGE_UP);
      fall_q <= (next_edge == EDGE_DOWN);
    end
  end

  assign level = level_q;
  assign rise  = rise_q;
  assign fall  = fall_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) run_cnt <= LAST); // R8
  AST_FLIP_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> $past(mismatch)); // R2
  AST_CHANGE_STROBED: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> (rise_q || fall_q)); // R5
  AST_RISE_MARKS_UP: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> (level_q && !$past(level_q))); // R5
  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q); // R5
  AST_FALL_MARKS_DOWN: assert property (@(posedge clk) disable iff (rst)
    fall_q |-> (!level_q && $past(level_q))); // R6
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fall_q |=> !fall_q); // R6
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rise_q && fall_q)); // R9

endmodule

// File: rtl/input_conditioner.sv
module input_conditioner
  import incond_pkg::*;
#(
  parameter int WAIT_CYCLES = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic noisy_in,
  output logic clean_level,
  output logic rise_pulse,
  output logic fall_pulse
);

  localparam int LATENCY = settle_latency(SYNC_STAGES, WAIT_CYCLES);

  logic synced;

  incond_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (noisy_in),
    .dout(synced)
  );

  incond_debounce #(
    .HOLD_CYCLES(WAIT_CYCLES)
  ) u_debounce (
    .clk   (clk),
    .rst   (rst),
    .sample(synced),
    .level (clean_level),
    .rise  (rise_pulse),
    .fall  (fall_pulse)
  );

  initial begin
    AST_LATENCY_SANE: assert (LATENCY >= 2); // R2
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!clean_level && !rise_pulse && !fall_pulse)); // R10
  AST_SYNC_CLEARED: assert property (@(posedge clk)
    rst |=> !synced); // R1

endmodule

// File: tb/input_conditioner_bench.sv
module input_conditioner_bench;

  localparam int WAIT = 10;
  localparam int LAT  = 2 + WAIT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic noisy_in = 1'b0;
  logic clean_level, rise_pulse, fall_pulse;

  int total = 0;
  int failed = 0;
  int n_rise = 0;
  int n_fall = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  input_conditioner #(.WAIT_CYCLES(WAIT), .SYNC_STAGES(2)) u_input_conditioner (
    .clk(clk), .rst(rst), .noisy_in(noisy_in),
    .clean_level(clean_level), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  // Strobe counters, sampled 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (rise_pulse) n_rise++;
    if (fall_pulse) n_fall++;
  end

  // Segment table: pin value, cycles held, then the level and the
  // cumulative strobe counts expected at the end of the segment.
  localparam int NSEG = 16;
  localparam int SEG_VAL [NSEG] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 1};
  localparam int SEG_LEN [NSEG] = '{9, 20, 10, 20, 3, 2, 5, 1, 30, 4, 20, 30, 9, 1, 11, 5};
  localparam int SEG_LVL [NSEG] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 1};
  localparam int SEG_RIS [NSEG] = '{0, 0, 0, 1, 1, 1, 1, 1, 2, 2, 2, 2, 2, 2, 2, 3};
  localparam int SEG_FAL [NSEG] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 2, 2, 2, 2, 2};

  task automatic check(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    // R1: reset state
    check("R1 level after reset", int'(clean_level), 0);
    check("R1 strobes after reset", int'(rise_pulse) + int'(fall_pulse), 0);
    rst = 1'b0;
    step(15);
    n_rise = 0;
    n_fall = 0;

    // Table walk: R3 glitch rejection, R4 boundary, R7 bounce,
    // R8 restart after interruption
    for (int i = 0; i < NSEG; i++) begin
      noisy_in = SEG_VAL[i][0];
      step(SEG_LEN[i]);
      check($sformatf("R3/R4/R7/R8 seg%0d level", i), int'(clean_level), SEG_LVL[i]);
      check($sformatf("R5 seg%0d rise count", i), n_rise, SEG_RIS[i]);
      check($sformatf("R6 seg%0d fall count", i), n_fall, SEG_FAL[i]);
    end

    // R2/R6: exact latency and single-cycle fall strobe (level is 1 here)
    noisy_in = 1'b0;
    step(LAT - 1);
    check("R2 level held before edge 12", int'(clean_level), 1);
    check("R6 no fall before change", int'(fall_pulse), 0);
    step(1);
    check("R2 level changes on edge 12", int'(clean_level), 0);
    check("R6 fall with level change", int'(fall_pulse), 1);
    check("R9 no rise with fall", int'(rise_pulse), 0);
    step(1);
    check("R6 fall lasts one cycle", int'(fall_pulse), 0);

    // R2/R5: exact latency and single-cycle rise strobe
    noisy_in = 1'b1;
    step(LAT - 1);
    check("R2 level held before edge 12 (up)", int'(clean_level), 0);
    step(1);
    check("R2 level changes on edge 12 (up)", int'(clean_level), 1);
    check("R5 rise with level change", int'(rise_pulse), 1);
    step(1);
    check("R5 rise lasts one cycle", int'(rise_pulse), 0);
    check("R5 level stays", int'(clean_level), 1);

    // R10: reset while level is 1, pin still high
    rst = 1'b1;
    step(1);
    check("R10 level cleared", int'(clean_level), 0);
    check("R10 strobes cleared", int'(rise_pulse) + int'(fall_pulse), 0);
    step(1);
    rst = 1'b0;
    step(LAT - 1);
    check("R10 full latency after release", int'(clean_level), 0);
    step(1);
    check("R10 level rises after full latency", int'(clean_level), 1);
    check("R10 rise strobe after release", int'(rise_pulse), 1);

    finish_run();
  end

endmodule